// File: doc/BRIEF.md
# APB Watchdog Countdown Timer

This block is a watchdog timer that sits on an APB slave port. A down-counter starts from a programmable reload value and moves one step on every clock cycle in which the tick-enable input is high. The tick-enable comes from a clock divider outside the block, so the divider alone sets the counting rate. When the count steps from one to zero, the block latches a raw interrupt flag. On the next tick it reloads and keeps counting, and the flag stays set until software writes to the clear register. That write also restarts the count from the reload value.

Two control bits enable counting together with the interrupt output, and enable a reset request. The reset request is raised when the count reaches zero a second time while the interrupt is still pending. A lock register protects the writable registers against stray writes: one key value unlocks them and any other value locks them.

Register offsets, as bus byte addresses: reload value 0x000, current count 0x004, control 0x008, interrupt clear 0x00C, raw status 0x010, masked status 0x014, lock 0xC00.

Top module: `wdog_apb_timer`

## Requirements
- R1: After reset, the reload value and the current count both read 0xFFFFFFFF, control reads 0, raw and masked status read 0, the lock register reads 0 (unlocked), and irq_o and rst_req_o are low.
- R2: A write to offset 0x000 stores the reload value and sets the current count to the written data in the same clock edge. Offset 0x004 is read-only, and writes to it have no effect.
- R3: When control bit 0 is 1, each cycle with tick_i high lowers the count by one. Cycles with tick_i low, and ticks while control bit 0 is 0, leave the count unchanged.
- R4: A tick that moves the count from 1 to 0 sets raw status bit 0 (offset 0x010), and the count then reads 0.
- R5: A tick while the count is 0 reloads the reload value, and raw status stays 1.
- R6: A write of any data to offset 0x00C clears raw status and reloads the count from the reload value. This takes priority over a tick in the same cycle.
- R7: irq_o and masked status bit 0 (offset 0x014) equal raw status AND control bit 0.
- R8: rst_req_o goes high when a tick moves the count from 1 to 0 while raw status is already 1 and control bit 1 is 1. It then stays high until reset, and a clear write does not drop it.
- R9: Writing 0x1ACCE551 to offset 0xC00 unlocks the registers, and writing any other value locks them. A read of offset 0xC00 returns 1 when locked and 0 when unlocked. While locked, writes to offsets 0x000, 0x008 and 0x00C have no effect.
- R10: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| tick_i | input | 1 | Count-enable pulse from an external divider |
| irq_o | output | 1 | Masked interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The hardest case to reach is a clear write, or a reload-value write, that lands in the same cycle as a tick. The bench reaches it by raising tick_i during the access phase of the APB write, and then checks that the count shows the reload value with no decrement applied. The second-timeout reset request needs a full reload cycle with the interrupt left pending. Small reload values keep that path short. A sweep over reload values 1 to 6, with varying idle gaps between ticks, checks the timing of the zero crossing, the wrap and the clear against arithmetic expectations.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [11:0] OFS_LOAD  = 12'h000;
  localparam logic [11:0] OFS_COUNT = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_CLR   = 12'h00C;
  localparam logic [11:0] OFS_RAW   = 12'h010;
  localparam logic [11:0] OFS_MSK   = 12'h014;
  localparam logic [11:0] OFS_LOCK  = 12'hC00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic res_en;
    logic int_en;
  } ctrl_t;

  typedef struct packed {
    logic load;
    logic ctrl;
    logic clr;
    logic lock;
  } wr_strobe_t;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output wr_strobe_t        wr_o
);
  logic wr_acc;
  logic [11:0] ofs;

  assign wr_acc = psel_i & penable_i & pwrite_i;
  assign ofs    = 12'(paddr_i);

  always_comb begin
    wr_o      = '0;
    wr_o.load = wr_acc && (ofs == OFS_LOAD);
    wr_o.ctrl = wr_acc && (ofs == OFS_CTRL);
    wr_o.clr  = wr_acc && (ofs == OFS_CLR);
    wr_o.lock = wr_acc && (ofs == OFS_LOCK);
  end

  always_comb begin
    AST_STROBE_ONEHOT: assert ($onehot0(wr_o)); // R9
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_strobe_t        wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  load_o,
  output ctrl_t             ctrl_o,
  output logic              locked_o,
  output logic              load_we_o,
  output logic              clr_we_o
);
  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q;
  logic             locked_q;

  assign load_we_o = wr_i.load & ~locked_q;
  assign clr_we_o  = wr_i.clr  & ~locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= '1;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (wr_i.lock) locked_q <= (32'(wdata_i) != UNLOCK_KEY);
      if (load_we_o) load_q <= wdata_i[CNT_W-1:0];
      if (wr_i.ctrl && !locked_q) ctrl_q <= ctrl_t'(wdata_i[1:0]);
    end
  end

  assign load_o   = load_q;
  assign ctrl_o   = ctrl_q;
  assign locked_o = locked_q;

  AST_LOCK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q && wr_i.load |=> $stable(load_q)); // R9
  AST_LOCK_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q && wr_i.ctrl |=> $stable(ctrl_q)); // R9
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             clr_we_i,
  output logic [CNT_W-1:0] count_o,
  output logic             raw_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic raw_q, rst_req_q;
  logic step, hit_zero;

  assign step     = tick_i & ctrl_i.int_en & ~load_we_i & ~clr_we_i;
  assign hit_zero = step & (count_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '1;
      raw_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (load_we_i)      count_q <= load_data_i;
      else if (clr_we_i)  count_q <= load_i;
      else if (step)      count_q <= (count_q == '0) ? load_i : count_q - ONE;

      if (clr_we_i)       raw_q <= 1'b0;
      else if (hit_zero)  raw_q <= 1'b1;

      if (hit_zero && raw_q && ctrl_i.res_en) rst_req_q <= 1'b1;
    end
  end

  assign count_o   = count_q;
  assign raw_o     = raw_q;
  assign rst_req_o = rst_req_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_we_i && !clr_we_i |=> $stable(count_q)); // R3
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && count_q != '0 |=> count_q == $past(count_q) - ONE); // R3
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && count_q == '0 |=> count_q == $past(load_i) && raw_q == $past(raw_q)); // R5
  AST_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && count_q == ONE |=> raw_q && count_q == '0); // R4
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> !raw_q && count_q == $past(load_i)); // R6
  AST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> rst_req_q); // R8
endmodule

// File: rtl/wdog_apb_timer.sv
module wdog_apb_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic              tick_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  wr_strobe_t       wr;
  logic [CNT_W-1:0] load_val, count;
  ctrl_t            ctrl;
  logic             locked, load_we, clr_we, raw, masked;

  wdog_decode #(.ADDR_W(ADDR_W)) u_decode (
    .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
    .paddr_i(paddr_i), .wr_o(wr)
  );

  wdog_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wdata_i(pwdata_i),
    .load_o(load_val), .ctrl_o(ctrl), .locked_o(locked),
    .load_we_o(load_we), .clr_we_o(clr_we)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ctrl_i(ctrl),
    .load_i(load_val), .load_we_i(load_we), .load_data_i(pwdata_i[CNT_W-1:0]),
    .clr_we_i(clr_we), .count_o(count), .raw_o(raw), .rst_req_o(rst_req_o)
  );

  assign masked = raw & ctrl.int_en;
  assign irq_o  = masked;

  always_comb begin
    prdata_o = '0;
    unique case (12'(paddr_i))
      OFS_LOAD:  prdata_o = DATA_W'(load_val);
      OFS_COUNT: prdata_o = DATA_W'(count);
      OFS_CTRL:  prdata_o = DATA_W'(ctrl);
      OFS_RAW:   prdata_o = DATA_W'(raw);
      OFS_MSK:   prdata_o = DATA_W'(masked);
      OFS_LOCK:  prdata_o = DATA_W'(locked);
      default:   prdata_o = '0;
    endcase
  end

  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raw && ctrl.int_en); // R7
endmodule

// File: tb/tb_wdog_apb_timer.sv
module tb_wdog_apb_timer;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, tick = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic irq, rst_req;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  wdog_apb_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .tick_i(tick), .irq_o(irq), .rst_req_o(rst_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic with_tick = 0);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; tick = with_tick;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic chk_rd(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_rd("R1 load", 12'h000, 32'hFFFF_FFFF);
    chk_rd("R1 count", 12'h004, 32'hFFFF_FFFF);
    chk_rd("R1 ctrl", 12'h008, 0);
    chk_rd("R1 raw", 12'h010, 0);
    chk_rd("R1 masked", 12'h014, 0);
    chk_rd("R1 lock", 12'hC00, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rst_req", {31'b0, rst_req}, 0);

    // R3 ticks ignored while disabled
    ticks(3, 0);
    chk_rd("R3 disabled hold", 12'h004, 32'hFFFF_FFFF);

    // sweep of reload values with varying gaps
    for (int l = 1; l <= 6; l++) begin
      wr(12'h000, l);
      wr(12'h008, 1);
      wr(12'h00C, 32'hDEAD_0000 + l);
      chk_rd("R6 start", 12'h004, l);
      chk_rd("R6 raw clear", 12'h010, 0);
      ticks(l - 1, l % 3);
      chk_rd("R3 count", 12'h004, 1);
      chk_rd("R4 raw before", 12'h010, 0);
      ticks(1, 0);
      chk_rd("R4 zero", 12'h004, 0);
      chk_rd("R4 raw", 12'h010, 1);
      chk_rd("R7 masked", 12'h014, 1);
      chk("R7 irq", {31'b0, irq}, 1);
      ticks(1, 2);
      chk_rd("R5 wrap", 12'h004, l);
      chk_rd("R5 raw held", 12'h010, 1);
      if (l > 1) begin
        ticks(1, 0);
        chk_rd("R3 after wrap", 12'h004, l - 1);
      end
      wr(12'h00C, 0);
      chk_rd("R6 reload", 12'h004, l);
      chk_rd("R6 raw", 12'h010, 0);
      chk("R8 no req", {31'b0, rst_req}, 0);
    end

    // R7 masking with int_en low
    wr(12'h000, 2); ticks(2, 0);
    chk_rd("R4 raw l2", 12'h010, 1);
    wr(12'h008, 0);
    chk_rd("R7 raw kept", 12'h010, 1);
    chk_rd("R7 masked off", 12'h014, 0);
    chk("R7 irq off", {31'b0, irq}, 0);
    wr(12'h008, 1);
    wr(12'h00C, 0);

    // R6 clear beats tick; R2 load reloads; count read-only
    wr(12'h000, 4);
    ticks(1, 0);
    chk_rd("R3 dec", 12'h004, 3);
    wr(12'h00C, 0, 1);
    chk_rd("R6 priority", 12'h004, 4);
    wr(12'h004, 7);
    chk_rd("R2 count ro", 12'h004, 4);
    ticks(1, 1);
    wr(12'h000, 9, 1);
    chk_rd("R2 immediate", 12'h004, 9);
    chk_rd("R2 load rd", 12'h000, 9);

    // R9 lock
    wr(12'hC00, 0);
    chk_rd("R9 locked", 12'hC00, 1);
    wr(12'h000, 5);
    chk_rd("R9 load held", 12'h000, 9);
    chk_rd("R9 count held", 12'h004, 9);
    wr(12'h008, 0);
    chk_rd("R9 ctrl held", 12'h008, 1);
    ticks(9, 0);
    chk_rd("R9 fired", 12'h010, 1);
    wr(12'h00C, 0);
    chk_rd("R9 clear blocked", 12'h010, 1);
    wr(12'hC00, 32'h1ACC_E551);
    chk_rd("R9 unlocked", 12'hC00, 0);
    wr(12'h00C, 0);
    chk_rd("R9 clear ok", 12'h010, 0);

    // R10 unmapped
    chk_rd("R10 unmapped", 12'h020, 0);
    chk_rd("R10 unmapped hi", 12'h800, 0);

    // R8 second timeout
    wr(12'h000, 2);
    wr(12'h008, 3);
    chk_rd("R8 ctrl", 12'h008, 3);
    wr(12'h00C, 0);
    ticks(2, 0);
    chk_rd("R8 first fire", 12'h010, 1);
    chk("R8 no req yet", {31'b0, rst_req}, 0);
    ticks(1, 0);
    chk("R8 wrap no req", {31'b0, rst_req}, 0);
    ticks(2, 1);
    chk("R8 req", {31'b0, rst_req}, 1);
    wr(12'h00C, 0);
    chk("R8 sticky", {31'b0, rst_req}, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R8 reset clears", {31'b0, rst_req}, 0);
    chk_rd("R1 re-reset count", 12'h004, 32'hFFFF_FFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule